// File: doc/BRIEF.md
# Thermometer Converter Acquisition and Signed Display Digits

This block sits between an external 8-bit analog-to-digital converter and a four-digit temperature readout. It runs the converter's three-wire control exchange: a single start strobe after reset, then, for every end-of-conversion it observes, an output-enable window in which the sample is captured from the converter's data bus. The analog front end is scaled so that a raw code of zero stands for -40 degrees.

Each captured code is shifted down by the offset and turned into a sign and a 7-bit magnitude. Readings above +127 clamp to 127. The magnitude is then split into hundreds, tens and ones BCD digits, with a leading sign digit. All four digits are registered together and announced by a one-cycle valid strobe. A display or control path downstream takes the digits on that strobe.

Top module: `thermo_acq`

## Requirements
- R1: While reset is held, `adc_start`, `adc_oe` and `rd_valid` are low and all four digits read 0. After reset is released, `adc_start` is high for exactly one cycle and never again.
- R2: `adc_oe` rises only after `adc_eoc` has been seen high. The reading is taken from `adc_data` while `adc_oe` is high.
- R3: For each conversion `adc_oe` is high for exactly two cycles. The block then waits for `adc_eoc` to go low before it accepts another conversion, so holding `adc_eoc` high yields only one reading.
- R4: A raw code of 40 or more gives sign digit 4'b0000 and magnitude code-40. Code 40 reads as +0.
- R5: A raw code below 40 gives sign digit 4'b1110 and magnitude 40-code.
- R6: `rd_hund`, `rd_tens` and `rd_ones` are the decimal hundreds, tens and ones of the magnitude, each in 0 to 9.
- R7: Raw codes above 167 give magnitude 127, with a positive sign.
- R8: `rd_valid` pulses for one cycle per conversion, in the first cycle after `adc_oe` falls. The digits change only in a cycle where `rd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_eoc | input | 1 | Converter end-of-conversion flag, asynchronous |
| adc_data | input | 8 | Converter output bus, driven while `adc_oe` is high |
| adc_start | output | 1 | Start strobe to the converter |
| adc_oe | output | 1 | Output enable for the converter's bus drivers |
| rd_valid | output | 1 | One-cycle strobe: new digits present |
| rd_sign | output | 4 | Sign digit, 0000 positive, 1110 negative |
| rd_hund | output | 4 | Hundreds BCD digit |
| rd_tens | output | 4 | Tens BCD digit |
| rd_ones | output | 4 | Ones BCD digit |

## Verification
The hardest situation to reach from the ports is an end-of-conversion flag that stays high after the output-enable window closes. A converter model that lowers the flag at once never tests whether the block re-arms too early. The bench therefore holds the flag high for several extra cycles on some conversions and confirms that exactly one reading appears. The arithmetic corners are each driven through the handshake: the offset boundary at codes 39, 40 and 41, the hundreds carry at 140, and the clamp at 167 and 168. A sweep of all 256 codes follows.

// File: rtl/thermo_acq_pkg.sv
package thermo_acq_pkg;

   localparam logic [3:0] SIGN_POS = 4'b0000;
   localparam logic [3:0] SIGN_NEG = 4'b1110;

   typedef enum logic [2:0] {
      HS_BOOT,
      HS_KICK,
      HS_WAIT_EOC,
      HS_READ,
      HS_HOLD,
      HS_WAIT_LOW
   } hs_state_t;

   typedef struct packed {
      logic [3:0] sign;
      logic [3:0] hund;
      logic [3:0] tens;
      logic [3:0] ones;
   } disp_digits_t;

endpackage

// File: rtl/thermo_adc_hs.sv
module thermo_adc_hs
   import thermo_acq_pkg::*;
#(
   parameter int ADC_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             eoc,
   input  logic [ADC_W-1:0] data,
   output logic             start,
   output logic             oe,
   output logic [ADC_W-1:0] smp,
   output logic             smp_vld
);

   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("thermo_adc_hs: SYNC_STAGES must be 0..4");
   end

   logic eoc_s;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign eoc_s = eoc;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk) begin
         if (!rst_n) sh <= '0;
         else        sh <= SYNC_STAGES'({sh, eoc});
      end
      assign eoc_s = sh[SYNC_STAGES-1];
   end

   hs_state_t st, st_nx;

   always_comb begin
      st_nx = st;
      unique case (st)
         HS_BOOT:     st_nx = HS_KICK;
         HS_KICK:     st_nx = HS_WAIT_EOC;
         HS_WAIT_EOC: if (eoc_s) st_nx = HS_READ;
         HS_READ:     st_nx = HS_HOLD;
         HS_HOLD:     st_nx = HS_WAIT_LOW;
         HS_WAIT_LOW: if (!eoc_s) st_nx = HS_WAIT_EOC;
         default:     st_nx = HS_BOOT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= HS_BOOT;
         smp     <= '0;
         smp_vld <= 1'b0;
      end else begin
         st      <= st_nx;
         smp_vld <= (st == HS_READ);
         if (st == HS_READ) smp <= data;
      end
   end

   assign start = (st == HS_KICK);
   assign oe    = (st == HS_READ) || (st == HS_HOLD);

   assert_start_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !start);

   assert_oe_after_eoc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> $past(eoc_s));

   assert_oe_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |=> oe);

   assert_oe_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (oe && $past(oe)) |=> !oe);

endmodule

// File: rtl/thermo_signmag.sv
module thermo_signmag #(
   parameter int ADC_W       = 8,
   parameter int MAG_W       = 7,
   parameter int ZERO_OFFSET = 40
) (
   input  logic [ADC_W-1:0] raw,
   output logic             neg,
   output logic [MAG_W-1:0] mag
);

   localparam int MAG_MAX = (1 << MAG_W) - 1;

   if (MAG_W > ADC_W) begin : g_bad_mag
      $error("thermo_signmag: MAG_W must not exceed ADC_W");
   end
   if (ZERO_OFFSET > MAG_MAX || ZERO_OFFSET < 0) begin : g_bad_ofs
      $error("thermo_signmag: ZERO_OFFSET must fit the magnitude");
   end

   localparam logic [ADC_W:0] OFS = (ADC_W+1)'(ZERO_OFFSET);
   localparam logic [ADC_W:0] SAT = (ADC_W+1)'(MAG_MAX);

   logic [ADC_W:0] ext;
   logic [ADC_W:0] diff;

   always_comb begin
      ext = {1'b0, raw};
      if (ext < OFS) begin
         neg  = 1'b1;
         diff = OFS - ext;
      end else begin
         neg  = 1'b0;
         diff = ext - OFS;
      end
      if (diff > SAT) diff = SAT;
      mag = diff[MAG_W-1:0];
   end

endmodule

// File: rtl/thermo_bcd_split.sv
module thermo_bcd_split #(
   parameter int MAG_W     = 7,
   parameter int BCD_STYLE = 0
) (
   input  logic [MAG_W-1:0] mag,
   output logic [3:0]       hund,
   output logic [3:0]       tens,
   output logic [3:0]       ones
);

   if (MAG_W > 9) begin : g_bad_w
      $error("thermo_bcd_split: MAG_W above 9 needs a thousands digit");
   end

   if (BCD_STYLE == 0) begin : g_ladder
      always_comb begin
         int r, h, t;
         r = int'(mag);
         h = 0;
         t = 0;
         for (int i = 0; i < 9; i++) begin
            if (r >= 100) begin
               r = r - 100;
               h = h + 1;
            end
         end
         for (int i = 0; i < 9; i++) begin
            if (r >= 10) begin
               r = r - 10;
               t = t + 1;
            end
         end
         hund = 4'(h);
         tens = 4'(t);
         ones = 4'(r);
      end
   end else begin : g_divide
      always_comb begin
         int m;
         m    = int'(mag);
         hund = 4'(m / 100);
         tens = 4'((m / 10) % 10);
         ones = 4'(m % 10);
      end
   end

   always_comb begin
      if (!$isunknown(mag)) begin
         assert_digit_range_R6: assert (hund <= 4'd9 && tens <= 4'd9 && ones <= 4'd9);
      end
   end

endmodule

// File: rtl/thermo_acq.sv
module thermo_acq
   import thermo_acq_pkg::*;
#(
   parameter int ADC_W       = 8,
   parameter int MAG_W       = 7,
   parameter int ZERO_OFFSET = 40,
   parameter int SYNC_STAGES = 2,
   parameter int BCD_STYLE   = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adc_eoc,
   input  logic [ADC_W-1:0] adc_data,
   output logic             adc_start,
   output logic             adc_oe,
   output logic             rd_valid,
   output logic [3:0]       rd_sign,
   output logic [3:0]       rd_hund,
   output logic [3:0]       rd_tens,
   output logic [3:0]       rd_ones
);

   logic [ADC_W-1:0] smp;
   logic             smp_vld;
   logic             neg;
   logic [MAG_W-1:0] mag;
   logic [3:0]       d_h, d_t, d_o;
   disp_digits_t     dig_q;
   logic             vld_q;

   thermo_adc_hs #(.ADC_W(ADC_W), .SYNC_STAGES(SYNC_STAGES)) u_hs (
      .clk     (clk),
      .rst_n   (rst_n),
      .eoc     (adc_eoc),
      .data    (adc_data),
      .start   (adc_start),
      .oe      (adc_oe),
      .smp     (smp),
      .smp_vld (smp_vld)
   );

   thermo_signmag #(.ADC_W(ADC_W), .MAG_W(MAG_W), .ZERO_OFFSET(ZERO_OFFSET)) u_sm (
      .raw (smp),
      .neg (neg),
      .mag (mag)
   );

   thermo_bcd_split #(.MAG_W(MAG_W), .BCD_STYLE(BCD_STYLE)) u_bcd (
      .mag  (mag),
      .hund (d_h),
      .tens (d_t),
      .ones (d_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dig_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= smp_vld;
         if (smp_vld) begin
            dig_q.sign <= neg ? SIGN_NEG : SIGN_POS;
            dig_q.hund <= d_h;
            dig_q.tens <= d_t;
            dig_q.ones <= d_o;
         end
      end
   end

   assign rd_valid = vld_q;
   assign rd_sign  = dig_q.sign;
   assign rd_hund  = dig_q.hund;
   assign rd_tens  = dig_q.tens;
   assign rd_ones  = dig_q.ones;

   assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   assert_valid_after_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($past(adc_oe) && !adc_oe));

   assert_digits_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> $stable({rd_sign, rd_hund, rd_tens, rd_ones}));

   assert_sign_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (rd_sign == SIGN_POS || rd_sign == SIGN_NEG));

endmodule

// File: tb/sim_thermo_acq.sv
`timescale 1ns/1ps
module sim_thermo_acq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       adc_eoc = 1'b0;
   logic [7:0] adc_data;
   logic       adc_start, adc_oe, rd_valid;
   logic [3:0] rd_sign, rd_hund, rd_tens, rd_ones;

   int n_vec = 0;
   int n_bad = 0;
   int cur_code = 0;
   int code_q[$];
   int start_cnt = 0;
   int valid_cnt = 0;
   int conv_cnt = 0;
   int oe_run = 0;
   logic prev_oe = 1'b0;
   logic prev_eoc = 1'b0;
   logic [15:0] prev_dig = '0;
   bit done = 0;

   always #2 clk = ~clk;

   assign adc_data = adc_oe ? 8'(cur_code) : 8'h5A;

   thermo_acq u0 (
      .clk(clk), .rst_n(rst_n), .adc_eoc(adc_eoc), .adc_data(adc_data),
      .adc_start(adc_start), .adc_oe(adc_oe), .rd_valid(rd_valid),
      .rd_sign(rd_sign), .rd_hund(rd_hund), .rd_tens(rd_tens), .rd_ones(rd_ones)
   );

   function automatic logic [15:0] model(int code);
      int m;
      logic [3:0] s;
      if (code < 40) begin
         s = 4'hE;
         m = 40 - code;
      end else begin
         s = 4'h0;
         m = code - 40;
         if (m > 127) m = 127;
      end
      return {s, 4'(m / 100), 4'((m / 10) % 10), 4'(m % 10)};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [15:0] dig;
         dig = {rd_sign, rd_hund, rd_tens, rd_ones};
         if (adc_start) start_cnt++;
         if (adc_oe && !prev_oe)
            check(prev_eoc, "R2 oe rose without eoc", 32'(prev_eoc), 32'd1);
         if (adc_oe) oe_run++;
         if (!adc_oe && prev_oe) begin
            check(oe_run == 2, "R3 oe width", 32'(oe_run), 32'd2);
            oe_run = 0;
         end
         if (rd_valid) begin
            valid_cnt++;
            check(prev_oe && !adc_oe, "R8 valid timing", 32'(prev_oe), 32'd1);
            if (code_q.size() == 0) begin
               check(0, "R3 unexpected reading", 32'(dig), 32'd0);
            end else begin
               int c;
               string tag;
               c = code_q.pop_front();
               if (c > 167)     tag = "R7/R6 digits";
               else if (c < 40) tag = "R5/R6 digits";
               else             tag = "R4/R6 digits";
               check(dig == model(c), $sformatf("%s code=%0d", tag, c), 32'(dig), 32'(model(c)));
            end
         end else begin
            check(dig == prev_dig, "R8 digits changed without valid", 32'(dig), 32'(prev_dig));
         end
         prev_dig = dig;
         prev_oe  = adc_oe;
         prev_eoc = adc_eoc;
      end
   end

   task automatic conv(input int code, input int extra_hold);
      cur_code = code;
      code_q.push_back(code);
      conv_cnt++;
      @(negedge clk);
      adc_eoc = 1'b1;
      do @(negedge clk); while (!adc_oe);
      do @(negedge clk); while (adc_oe);
      repeat (extra_hold) @(negedge clk);
      adc_eoc = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!adc_start && !adc_oe && !rd_valid, "R1 controls in reset",
            32'({adc_start, adc_oe, rd_valid}), 32'd0);
      check({rd_sign, rd_hund, rd_tens, rd_ones} == 16'h0, "R1 digits in reset",
            32'({rd_sign, rd_hund, rd_tens, rd_ones}), 32'd0);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      check(start_cnt == 1, "R1 start pulse count", 32'(start_cnt), 32'd1);

      conv(0, 0);     // R5 coldest
      conv(39, 0);    // R5 -1
      conv(40, 0);    // R4 zero
      conv(41, 0);    // R4 +1
      conv(65, 6);    // R3 eoc held long
      conv(12, 0);    // R5
      conv(139, 0);   // R6 99
      conv(140, 9);   // R6 100, R3 held
      conv(167, 0);   // R7 edge 127
      conv(168, 0);   // R7 saturate
      conv(255, 3);   // R7 saturate
      for (int c = 0; c < 256; c++) conv(c, c % 3);

      repeat (10) @(negedge clk);
      check(code_q.size() == 0, "R8 missing readings", 32'(code_q.size()), 32'd0);
      check(valid_cnt == conv_cnt, "R3 one reading per conversion", 32'(valid_cnt), 32'(conv_cnt));
      check(start_cnt == 1, "R1 no second start", 32'(start_cnt), 32'd1);
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_vec++;
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", conv_cnt, 267);
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule